// File: doc/BRIEF.md
# Timer Compare and Overflow Interrupt Flag Unit

This block keeps the interrupt status and enable state for one 8-bit timer/counter. The counter is outside the block. The block watches the counter value and its counting direction, and it raises two latched events. The compare event fires when the counter becomes equal to a programmable compare value. The overflow event fires when the counter wraps in normal mode, or when it turns from counting down to counting up at zero in phase-correct mode.

Each event sets a sticky flag. Software clears a flag by writing a one to its bit, and the interrupt controller clears it by pulsing that source's acknowledge line. Each source's request line is a registered AND of a global enable, that source's enable bit and that source's flag. A small register bus gives access to three registers: the compare value at address 0, the enable bits at address 1 and the flag bits at address 2. Reads are combinational. Writes take effect at the next clock edge.

Two small state machines detect the events. The compare detector has two states. CMP_APART moves to CMP_EQUAL when the counter equals the compare value, and CMP_EQUAL moves back to CMP_APART when they differ. A compare event is the CMP_APART to CMP_EQUAL transition. The overflow detector also has two states. It enters OV_ARMED when the last sampled count was the maximum (normal mode) or the last sampled direction was down (phase-correct mode), and it stays in OV_IDLE otherwise. An overflow event is a sample in OV_ARMED with the counter at zero, with the direction up if the mode is phase-correct.

Top module: `tmr_irq_flags`

## Requirements
- R1: The compare register is 8 bits wide at address 0. It resets to 0 and reads back the last value written.
- R2: The compare flag (bit 1) and the `match_o` pulse go high one cycle after a clock edge samples `cnt_i` equal to the compare value while the previous sample was not equal. `match_o` lasts one cycle and does not repeat while the two stay equal.
- R3: In normal mode (`pc_mode_i`=0), the overflow flag (bit 0) sets after a clock edge that samples `cnt_i`=0 when the previous sample was 255.
- R4: In phase-correct mode (`pc_mode_i`=1), the overflow flag sets after a clock edge that samples `cnt_i`=0 with `cnt_up_i`=1 when the previous sample had `cnt_up_i`=0. A 255-to-0 wrap in this mode does not set it.
- R5: A write to address 2 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R6: A pulse on `ack_cmp_i` clears the compare flag, and a pulse on `ack_ovf_i` clears the overflow flag, at the next edge.
- R7: If a flag's set event and a clear (write-one or acknowledge) occur in the same cycle, the flag ends up set.
- R8: Each `irq_*_o` output equals the value of `gie_i` AND enable bit AND flag bit from the previous cycle.
- R9: The enable register (address 1) and the flag register (address 2) use bit 1 for compare and bit 0 for overflow. Their bits 7 to 2 read as 0 and ignore writes. Both reset to 0.
- R10: `bus_rdata_o` shows the addressed register in the same cycle. Address 3 reads 0. A write becomes visible after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 8 | Current counter value |
| cnt_up_i | input | 1 | Counting direction, 1 = up |
| pc_mode_i | input | 1 | 1 = phase-correct mode |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| gie_i | input | 1 | Global interrupt enable |
| ack_cmp_i | input | 1 | Compare vector acknowledge |
| ack_ovf_i | input | 1 | Overflow vector acknowledge |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| match_o | output | 1 | One-cycle compare match pulse |

## Verification
The hardest case to reach is a set event and a clear that land in the same cycle. To get there, the counter has to arrive at the compare value, or at the phase-correct turnaround at zero, in exactly the cycle that a write-one or an acknowledge is presented. The bench produces this case with directed sequences that step the counter to the compare value while clearing the flag in that same cycle. Its random phase also jumps the counter straight to the compare value, 0 and 255 often, while issuing random flag writes and acknowledges. A bench model follows the detector states, so every one of those collisions is checked.

// File: rtl/tif_pkg.sv
package tif_pkg;
    localparam int CNT_W   = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NSRC    = 2;
    localparam int SRC_OVF = 0;
    localparam int SRC_CMP = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMP  = 2'd0,
        REG_EN   = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {CMP_APART, CMP_EQUAL} cmp_state_e;
    typedef enum logic {OV_IDLE, OV_ARMED} ovf_state_e;
endpackage

// File: rtl/tif_cmp_fsm.sv
module tif_cmp_fsm
    import tif_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    output logic         hit_o,
    output logic         match_o
);
    cmp_state_e state_q, state_d;
    logic       eq;
    logic       match_q;

    assign eq = (cnt_i == cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_APART;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        unique case (state_q)
            CMP_APART: if (eq)  begin state_d = CMP_EQUAL; hit_o = 1'b1; end
            CMP_EQUAL: if (!eq) state_d = CMP_APART;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= hit_o;
    end

    assign match_o = match_q;
endmodule

// File: rtl/tif_ovf_fsm.sv
module tif_ovf_fsm
    import tif_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         up_i,
    input  logic         pc_i,
    output logic         hit_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    ovf_state_e state_q, state_d;
    logic       arm;
    logic       at_zero;

    assign arm     = pc_i ? !up_i : (cnt_i == TOP);
    assign at_zero = (cnt_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = arm ? OV_ARMED : OV_IDLE;
        hit_o   = 1'b0;
        unique case (state_q)
            OV_IDLE:  hit_o = 1'b0;
            OV_ARMED: hit_o = at_zero && (!pc_i || up_i);
        endcase
    end
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] wclr_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] en_i,
    input  logic         gie_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] irq_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic flag_q;
        logic irq_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                irq_q  <= 1'b0;
            end else begin
                flag_q <= set_i[i] | (flag_q & ~(wclr_i[i] | ack_i[i]));
                irq_q  <= gie_i & en_i[i] & flag_q;
            end
        end

        assign flag_o[i] = flag_q;
        assign irq_o[i]  = irq_q;
    end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cnt_up_i,
    input  logic              pc_mode_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              gie_i,
    input  logic              ack_cmp_i,
    input  logic              ack_ovf_i,
    output logic              irq_cmp_o,
    output logic              irq_ovf_o,
    output logic              match_o
);
    localparam int PAD_W = DATA_W - NSRC;

    logic [CNT_W-1:0] cmp_q;
    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  flag_q;
    logic [NSRC-1:0]  irq_vec;
    logic [NSRC-1:0]  set_vec;
    logic [NSRC-1:0]  ack_vec;
    logic [NSRC-1:0]  wclr_vec;
    logic             cmp_hit;
    logic             ovf_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            en_q  <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == REG_CMP) cmp_q <= bus_wdata_i[CNT_W-1:0];
            if (bus_addr_i == REG_EN)  en_q  <= bus_wdata_i[NSRC-1:0];
        end
    end

    assign wclr_vec = (bus_we_i && bus_addr_i == REG_FLAG) ? bus_wdata_i[NSRC-1:0] : '0;

    always_comb begin
        set_vec          = '0;
        ack_vec          = '0;
        set_vec[SRC_CMP] = cmp_hit;
        set_vec[SRC_OVF] = ovf_hit;
        ack_vec[SRC_CMP] = ack_cmp_i;
        ack_vec[SRC_OVF] = ack_ovf_i;
    end

    tif_cmp_fsm #(.W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .cmp_i   (cmp_q),
        .hit_o   (cmp_hit),
        .match_o (match_o)
    );

    tif_ovf_fsm #(.W(CNT_W)) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (cnt_i),
        .up_i  (cnt_up_i),
        .pc_i  (pc_mode_i),
        .hit_o (ovf_hit)
    );

    tif_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wclr_i (wclr_vec),
        .ack_i  (ack_vec),
        .en_i   (en_q),
        .gie_i  (gie_i),
        .flag_o (flag_q),
        .irq_o  (irq_vec)
    );

    assign irq_cmp_o = irq_vec[SRC_CMP];
    assign irq_ovf_o = irq_vec[SRC_OVF];

    always_comb begin
        unique case (bus_addr_i)
            REG_CMP:  bus_rdata_o = {{(DATA_W-CNT_W){1'b0}}, cmp_q};
            REG_EN:   bus_rdata_o = {{PAD_W{1'b0}}, en_q};
            REG_FLAG: bus_rdata_o = {{PAD_W{1'b0}}, flag_q};
            REG_NONE: bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/tif_checker.sv
module tif_checker
    import tif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              gie_i,
    input logic              ack_cmp_i,
    input logic              ack_ovf_i,
    input logic              irq_cmp_o,
    input logic              irq_ovf_o,
    input logic              match_o,
    input logic [NSRC-1:0]   flag_q,
    input logic [NSRC-1:0]   en_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic              cmp_hit,
    input logic              ovf_hit
);
    a_r1_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == REG_CMP) |=> (cmp_q == $past(bus_wdata_i[CNT_W-1:0])));

    a_r2_match_single: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    a_r2_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> flag_q[SRC_CMP]);

    a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> flag_q[SRC_OVF]);

    a_r5_wclr_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == REG_FLAG && bus_wdata_i[SRC_CMP] && !cmp_hit)
        |=> !flag_q[SRC_CMP]);

    a_r6_ack_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf_i && !ovf_hit) |=> !flag_q[SRC_OVF]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && (ack_cmp_i || (bus_we_i && bus_addr_i == REG_FLAG))) |=> flag_q[SRC_CMP]);

    a_r8_irq_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_i && en_q[SRC_CMP] && flag_q[SRC_CMP]) |=> irq_cmp_o);

    a_r8_irq_ovf_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf_o |-> $past(gie_i && en_q[SRC_OVF] && flag_q[SRC_OVF]));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == REG_EN || bus_addr_i == REG_FLAG)
        |-> (bus_rdata_o[DATA_W-1:NSRC] == '0));
endmodule

bind tmr_irq_flags tif_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .gie_i       (gie_i),
    .ack_cmp_i   (ack_cmp_i),
    .ack_ovf_i   (ack_ovf_i),
    .irq_cmp_o   (irq_cmp_o),
    .irq_ovf_o   (irq_ovf_o),
    .match_o     (match_o),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .cmp_q       (cmp_q),
    .cmp_hit     (cmp_hit),
    .ovf_hit     (ovf_hit)
);

// File: tb/sim_tmr_irq_flags.sv
`timescale 1ns/1ps
module sim_tmr_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cnt_i = 8'd5;
    logic       cnt_up_i = 1'b1;
    logic       pc_mode_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic       bus_we_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'd0;
    logic [7:0] bus_rdata_o;
    logic       gie_i = 1'b0;
    logic       ack_cmp_i = 1'b0;
    logic       ack_ovf_i = 1'b0;
    logic       irq_cmp_o, irq_ovf_o, match_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_cmp;
    logic [1:0] m_en, m_flag, m_irq;
    logic       m_match, m_eqst, m_arm;

    always #2 clk = ~clk;

    tmr_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_up_i(cnt_up_i),
        .pc_mode_i(pc_mode_i), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .gie_i(gie_i),
        .ack_cmp_i(ack_cmp_i), .ack_ovf_i(ack_ovf_i), .irq_cmp_o(irq_cmp_o),
        .irq_ovf_o(irq_ovf_o), .match_o(match_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmp;
            2'd1:    return {6'd0, m_en};
            2'd2:    return {6'd0, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R1";
            2'd1:    return "R9";
            2'd2:    return "R5";
            default: return "R10";
        endcase
    endfunction

    // Called at a negative edge; returns at the next negative edge.
    task automatic step(input logic [7:0] c, input logic up, input logic pc,
                        input logic [1:0] a, input logic we, input logic [7:0] wd,
                        input logic g, input logic ac, input logic ao, input string tag);
        logic       eq, chit, ohit;
        logic [1:0] clr, nirq;
        cnt_i = c; cnt_up_i = up; pc_mode_i = pc; bus_addr_i = a; bus_we_i = we;
        bus_wdata_i = wd; gie_i = g; ack_cmp_i = ac; ack_ovf_i = ao;
        #1;
        check((tag == "") ? rd_tag(a) : tag, bus_rdata_o, exp_rd(a));
        @(posedge clk);
        eq   = (c == m_cmp);
        chit = eq && !m_eqst;
        ohit = m_arm && (c == 8'd0) && (!pc || up);
        clr  = ((we && a == 2'd2) ? wd[1:0] : 2'b00) | {ac, ao};
        nirq = {g & m_en[1] & m_flag[1], g & m_en[0] & m_flag[0]};
        m_flag  = (m_flag & ~clr) | {chit, ohit};
        m_irq   = nirq;
        m_match = chit;
        m_eqst  = eq;
        m_arm   = pc ? !up : (c == 8'hFF);
        if (we && a == 2'd0) m_cmp = wd;
        if (we && a == 2'd1) m_en = wd[1:0];
        #1;
        check("R2", {7'd0, match_o}, {7'd0, m_match});
        check("R8", {7'd0, irq_cmp_o}, {7'd0, m_irq[1]});
        check("R8", {7'd0, irq_ovf_o}, {7'd0, m_irq[0]});
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rc;
        logic       rup, rpc;
        void'($urandom(32'd20240613));
        m_cmp = 0; m_en = 0; m_flag = 0; m_irq = 0; m_match = 0; m_eqst = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state, R1 R9 R10
        step(8'd5, 1, 0, 2'd0, 0, 8'd0, 0, 0, 0, "R1");
        step(8'd5, 1, 0, 2'd1, 0, 8'd0, 0, 0, 0, "R9");
        step(8'd5, 1, 0, 2'd2, 0, 8'd0, 0, 0, 0, "R9");
        step(8'd5, 1, 0, 2'd3, 0, 8'd0, 0, 0, 0, "R10");
        // write compare and enables (upper bits ignored), read back next cycle R10
        step(8'd5, 1, 0, 2'd0, 1, 8'd10, 1, 0, 0, "R1");
        step(8'd5, 1, 0, 2'd0, 0, 8'd0, 1, 0, 0, "R10");
        step(8'd5, 1, 0, 2'd1, 1, 8'hFF, 1, 0, 0, "R9");
        step(8'd5, 1, 0, 2'd1, 0, 8'd0, 1, 0, 0, "R9");
        step(8'd5, 1, 0, 2'd3, 1, 8'hAA, 1, 0, 0, "R10");
        // R7: match arrives with write-one clear in the same cycle
        step(8'd9, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R2");
        step(8'd10, 1, 0, 2'd2, 1, 8'h02, 1, 0, 0, "R7");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R7");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R2");
        // R5: write zero to the compare bit leaves it, write one clears
        step(8'd10, 1, 0, 2'd2, 1, 8'h01, 1, 0, 0, "R5");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R5");
        step(8'd10, 1, 0, 2'd2, 1, 8'hFE, 1, 0, 0, "R5");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R5");
        // R6: acknowledge clears compare flag; R7 via acknowledge collision
        step(8'd11, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R2");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R2");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 1, 0, "R6");
        step(8'd11, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R6");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 1, 0, "R7");
        step(8'd10, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R7");
        // R3: normal wrap
        step(8'd254, 1, 0, 2'd2, 1, 8'h03, 1, 0, 0, "R5");
        step(8'd255, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R3");
        step(8'd0, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R3");
        step(8'd1, 1, 0, 2'd2, 0, 8'd0, 1, 0, 0, "R3");
        step(8'd2, 1, 0, 2'd2, 0, 8'd0, 0, 0, 1, "R6");
        step(8'd3, 1, 0, 2'd2, 0, 8'd0, 0, 0, 0, "R6");
        // R4: phase-correct wrap ignored, turnaround at zero sets
        step(8'd255, 1, 1, 2'd2, 0, 8'd0, 1, 0, 0, "R4");
        step(8'd0, 1, 1, 2'd2, 0, 8'd0, 1, 0, 0, "R4");
        step(8'd1, 1, 1, 2'd2, 0, 8'd0, 1, 0, 0, "R4");
        step(8'd1, 0, 1, 2'd2, 0, 8'd0, 1, 0, 0, "R4");
        step(8'd0, 1, 1, 2'd2, 1, 8'h01, 1, 0, 0, "R4");
        step(8'd1, 1, 1, 2'd2, 0, 8'd0, 1, 0, 0, "R7");
        step(8'd2, 1, 1, 2'd2, 0, 8'd0, 0, 0, 0, "R8");
        // constrained random phase
        rc = 8'd0; rup = 1'b1; rpc = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] a;
            logic we;
            logic [7:0] wd;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 199) == 0) rpc = ~rpc;
            if (r < 8)       rc = m_cmp;
            else if (r < 13) rc = 8'd0;
            else if (r < 18) rc = 8'hFF;
            else if (r < 22) rc = 8'($urandom);
            else if (rpc) begin
                if ($urandom_range(0, 15) == 0) rup = ~rup;
                rc = rup ? rc + 8'd1 : rc - 8'd1;
            end else begin
                rc  = rc + 8'd1;
                rup = 1'b1;
            end
            a  = 2'($urandom);
            we = ($urandom_range(0, 5) == 0);
            wd = (a == 2'd0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
            step(rc, rup, rpc, a, we, wd, ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), "");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule